// File: doc/BRIEF.md
# Dual-Mode Multiplexed Host Bus Interface

This block turns a host processor's 8-bit multiplexed address/data bus into a simple internal register-file port. A strap input selects one of two strobe conventions. In the first, the three control pins act as read strobe, address latch enable and write strobe. In the second, they act as data strobe, address strobe and read/write select. In both modes, a rising edge on the latch pin captures the address that the host places on the shared bus. A data phase follows. It is gated by an active-low chip select and writes a byte into the register file or reads a byte back out of it.

A fast system clock samples every host pin through a synchronizer, and edges are found by comparing successive samples, so the whole block stays synchronous. The bidirectional pad is split into input, output and output-enable. The block drives the bus only while a read is in progress. A test input overrides that drive at once. The register file sits outside the block. It sees the latched address, a one-cycle write pulse with data, and a one-cycle read pulse. It must return read data combinationally from the address.

The register-file side is a plain control interface with no back-pressure. The file must accept a write pulse in any cycle, and it must present data in the same cycle as the read pulse.

Top module: `hbi_top`

## Requirements
- R1: After reset, rf_we, rf_re and bus_oe are 0 and rf_addr is 0.
- R2: A rising edge on ctl_b (address latch enable / address strobe) loads rf_addr from the bus, in both modes and whatever the state of cs_n. Between such edges, rf_addr holds its value while the bus changes.
- R3: With mode=0, ctl_c is an active-low write strobe. A rising edge of ctl_c while cs_n is low produces a write pulse on rf_we. The pulse carries on rf_wdata the bus byte present while the strobe was low.
- R4: With mode=0, ctl_a is an active-low read strobe. While cs_n and ctl_a are both low, bus_oe is 1 and bus_out carries the register-file byte at rf_addr. bus_oe returns to 0 after ctl_a rises.
- R5: With mode=1, ctl_a is an active-low data strobe and ctl_c is read/write (1 = read, 0 = write). With ctl_c low and cs_n low, a rising edge of ctl_a commits the bus byte as a write.
- R6: With mode=1, while cs_n and ctl_a are low and ctl_c is high, bus_oe is 1 and bus_out carries the byte at rf_addr.
- R7: While cs_n is high, strobes produce no rf_we, no rf_re and no bus drive.
- R8: While tri_off is 1, bus_oe is 0 in the same cycle, even in the middle of a read. Removing tri_off while the read continues restores the drive.
- R9: Each completed write gives exactly one cycle of rf_we, and each read gives exactly one cycle of rf_re.
- R10: With mode=1, a data-strobe pulse with ctl_c high produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the host strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 1 | Strap: 0 = read/latch/write pins, 1 = data strobe/address strobe/read-write pins |
| tri_off | input | 1 | Test input; 1 forces the bus drivers off |
| cs_n | input | 1 | Active-low chip select |
| ctl_a | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| ctl_b | input | 1 | Address latch enable / address strobe, rising edge captures address |
| ctl_c | input | 1 | Write strobe, active low (mode 0) or read/write select (mode 1) |
| bus_in | input | DATA_W | Bus pad input |
| bus_out | output | DATA_W | Bus pad output value |
| bus_oe | output | 1 | Bus pad output enable |
| rf_addr | output | ADDR_W | Latched register address |
| rf_wdata | output | DATA_W | Write data |
| rf_we | output | 1 | One-cycle write pulse |
| rf_re | output | 1 | One-cycle read pulse |
| rf_rdata | input | DATA_W | Read data, valid combinationally for rf_addr |

## Verification
The bench builds the block with the defaults: an 8-bit bus, 8-bit address and two synchronizer stages. It holds every pin level for six clocks, which covers the three-register path from pin to bus_oe and to the write pulse. The bench writes bytes in one mode and reads them back in the other, so a mix-up of pin meanings between the modes shows up as wrong data. The cases with chip select held off, with read/write high, and with the test override in mid-read exercise the gating paths.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic {
    BUS_SPLIT_RW = 1'b0,
    BUS_STROBE_DIR = 1'b1
  } bus_kind_e;

  typedef struct packed {
    logic cs_n;
    logic ca;
    logic cb;
    logic cc;
  } pins_t;

  localparam int PINS_W = 4;
  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, ca: 1'b1, cb: 1'b0, cc: 1'b1};
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else chain[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbi_decode.sv
module hbi_decode
  import hbi_pkg::*;
(
  input  bus_kind_e kind,
  input  pins_t     cur,
  input  pins_t     prv,
  output logic      latch_rise,
  output logic      rd_active,
  output logic      wr_active,
  output logic      wr_commit
);
  always_comb begin
    latch_rise = cur.cb & ~prv.cb;
    if (kind == BUS_STROBE_DIR) begin
      rd_active = ~cur.cs_n & ~cur.ca & cur.cc;
      wr_active = ~cur.cs_n & ~cur.ca & ~cur.cc;
      wr_commit = ~prv.ca & cur.ca & ~prv.cs_n & ~prv.cc;
    end else begin
      rd_active = ~cur.cs_n & ~cur.ca;
      wr_active = ~cur.cs_n & ~cur.cc;
      wr_commit = ~prv.cc & cur.cc & ~prv.cs_n;
    end
  end
endmodule

// File: rtl/hbi_top.sv
module hbi_top
  import hbi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              tri_off,
  input  logic              cs_n,
  input  logic              ctl_a,
  input  logic              ctl_b,
  input  logic              ctl_c,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic              rf_re,
  input  logic [DATA_W-1:0] rf_rdata
);
  pins_t pins_raw, pins_s, pins_p;
  logic [DATA_W-1:0] bus_s;
  logic latch_rise, rd_active, wr_active, wr_commit;
  logic rd_q;
  logic [DATA_W-1:0] wdat_q, rdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic we_q;
  bus_kind_e kind;

  assign kind = bus_kind_e'(mode);
  assign pins_raw = '{cs_n: cs_n, ca: ctl_a, cb: ctl_b, cc: ctl_c};

  hbi_sync #(.W(PINS_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  hbi_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(bus_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_p <= PINS_IDLE;
    else pins_p <= pins_s;
  end

  hbi_decode u_dec (
    .kind(kind), .cur(pins_s), .prv(pins_p),
    .latch_rise(latch_rise), .rd_active(rd_active),
    .wr_active(wr_active), .wr_commit(wr_commit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdat_q  <= '0;
      wd_q    <= '0;
      we_q    <= 1'b0;
      rd_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (latch_rise) addr_q <= bus_s[ADDR_W-1:0];
      if (wr_active) wdat_q <= bus_s;
      we_q <= wr_commit;
      if (wr_commit) wd_q <= wdat_q;
      rd_q <= rd_active;
      if (rd_active && !rd_q) rdata_q <= rf_rdata;
    end
  end

  assign rf_addr  = addr_q;
  assign rf_wdata = wd_q;
  assign rf_we    = we_q;
  assign rf_re    = rd_active & ~rd_q;
  assign bus_out  = rdata_q;
  assign bus_oe   = rd_q & ~tri_off;

  // R9: write pulse lasts one cycle
  a_r9_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);
  // R9: read pulse lasts one cycle
  a_r9_re_single: assert property (@(posedge clk) disable iff (!rst_n)
    rf_re |=> !rf_re);
  // R4/R6: a started read drives the bus next cycle unless test forces off
  a_r4_re_then_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rf_re |=> (bus_oe || tri_off));
  // R2: address only moves after a latch edge
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_rise |=> $stable(rf_addr));
  // R7: a write commit never follows a sample with chip select off
  a_r7_we_cs: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !$past(pins_p.cs_n));
endmodule

// File: tb/tb_hbi_top.sv
`timescale 1ns/1ps
module tb_hbi_top;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int HOLD = 6;

  logic clk = 0, rst_n = 0;
  logic mode = 0, tri_off = 0, cs_n = 1, ctl_a = 1, ctl_b = 0, ctl_c = 1;
  logic [DW-1:0] bus_in = '0, bus_out, rf_wdata, rf_rdata;
  logic bus_oe, rf_we, rf_re;
  logic [AW-1:0] rf_addr;
  logic [DW-1:0] mem [256];
  int checks = 0, errors = 0, we_cnt = 0, re_cnt = 0;

  always #2.5 clk = ~clk;

  hbi_top #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tri_off(tri_off), .cs_n(cs_n),
    .ctl_a(ctl_a), .ctl_b(ctl_b), .ctl_c(ctl_c), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .rf_we(rf_we), .rf_re(rf_re), .rf_rdata(rf_rdata)
  );

  assign rf_rdata = mem[rf_addr];

  always @(posedge clk) begin
    if (rf_we) begin mem[rf_addr] <= rf_wdata; we_cnt <= we_cnt + 1; end
    if (rf_re) re_cnt <= re_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle(input logic m);
    mode = m; cs_n = 1; ctl_a = 1; ctl_b = 0; ctl_c = 1; hold(HOLD);
  endtask

  task automatic latch(input logic [7:0] a);
    bus_in = a; ctl_b = 1; hold(HOLD); ctl_b = 0; hold(HOLD);
  endtask

  task automatic do_write(input logic m, input logic [7:0] a, input logic [7:0] d, input logic sel);
    idle(m); latch(a); bus_in = d;
    cs_n = ~sel;
    if (m) begin ctl_c = 0; hold(HOLD); ctl_a = 0; hold(HOLD); ctl_a = 1; hold(HOLD); ctl_c = 1; end
    else begin ctl_c = 0; hold(HOLD); ctl_c = 1; hold(HOLD); end
    cs_n = 1; hold(HOLD);
  endtask

  // starts a read and leaves it active
  task automatic read_open(input logic m, input logic [7:0] a, input logic sel);
    idle(m); latch(a); bus_in = 8'h00; cs_n = ~sel;
    ctl_c = 1; ctl_a = 0; hold(HOLD);
  endtask

  task automatic read_close();
    ctl_a = 1; hold(HOLD); cs_n = 1; hold(HOLD);
  endtask

  // {mode, addr, data}: write in mode, read back in the other mode
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'h05, 8'hA5}, {1'b1, 8'h3C, 8'h5A}, {1'b0, 8'hFF, 8'h00},
    {1'b1, 8'h00, 8'hFF}, {1'b0, 8'h81, 8'h7E}, {1'b1, 8'h42, 8'h13}
  };

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    hold(3);
    chk("R1 we", rf_we, 0); chk("R1 re", rf_re, 0);
    chk("R1 oe", bus_oe, 0); chk("R1 addr", rf_addr, 0);
    rst_n = 1; hold(2);

    for (int i = 0; i < 6; i++) begin
      logic m; logic [7:0] a, d; int w0, r0;
      {m, a, d} = VEC[i];
      w0 = we_cnt;
      do_write(m, a, d, 1'b1);
      chk(m ? "R5 write count" : "R3 write count", we_cnt - w0, 1);
      chk(m ? "R5 write data" : "R3 write data", mem[a], d);
      r0 = re_cnt;
      read_open(~m, a, 1'b1);
      chk(m ? "R4 oe" : "R6 oe", bus_oe, 1);
      chk(m ? "R4 data" : "R6 data", bus_out, d);
      read_close();
      chk("R4 oe released", bus_oe, 0);
      chk("R9 single re", re_cnt - r0, 1);
    end

    // R2: address holds while bus changes
    idle(0); latch(8'h6B); bus_in = 8'h11; hold(HOLD);
    chk("R2 addr latched", rf_addr, 8'h6B);
    bus_in = 8'h99; hold(HOLD);
    chk("R2 addr held", rf_addr, 8'h6B);
    // R2: latch with chip select off still loads
    idle(1); cs_n = 1; latch(8'h27);
    chk("R2 addr mode1", rf_addr, 8'h27);

    // R7: chip select off, write ignored in both modes
    begin
      int w0;
      w0 = we_cnt;
      do_write(0, 8'h05, 8'h11, 1'b0);
      do_write(1, 8'h05, 8'h22, 1'b0);
      chk("R7 no write count", we_cnt - w0, 0);
      chk("R7 mem kept", mem[8'h05], 8'hA5);
    end
    begin
      int r0;
      r0 = re_cnt;
      read_open(0, 8'h05, 1'b0);
      chk("R7 no drive", bus_oe, 0);
      read_close();
      chk("R7 no re", re_cnt - r0, 0);
    end

    // R10: data strobe with read/write high gives no write
    begin
      int w0;
      w0 = we_cnt;
      idle(1); latch(8'h3C); bus_in = 8'h77; cs_n = 0; ctl_c = 1;
      ctl_a = 0; hold(HOLD); ctl_a = 1; hold(HOLD); cs_n = 1; hold(HOLD);
      chk("R10 no write", we_cnt - w0, 0);
      chk("R10 mem kept", mem[8'h3C], 8'h5A);
    end

    // R8: test override mid-read
    read_open(0, 8'h81, 1'b1);
    chk("R8 drive before", bus_oe, 1);
    tri_off = 1; #1;
    chk("R8 forced off", bus_oe, 0);
    hold(2);
    chk("R8 still off", bus_oe, 0);
    tri_off = 0; #1;
    chk("R8 restored", bus_oe, 1);
    chk("R8 data", bus_out, 8'h7E);
    read_close();

    // R9: back-to-back writes each give one pulse
    begin
      int w0;
      w0 = we_cnt;
      do_write(0, 8'h10, 8'h01, 1'b1);
      do_write(0, 8'h10, 8'h02, 1'b1);
      chk("R9 two writes", we_cnt - w0, 2);
      chk("R3 last data", mem[8'h10], 8'h02);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule